// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block derives the serial clock for a shift-register interface from the system clock. A programmable prescaler divides the system clock into ticks. A compare counter then steps once per tick through the values 0 to W, where W is the wrap point. The line turns active after the tick taken at the high point H. It returns to rest after the tick taken at the wrap point W, and that same tick restarts the count. One serial period therefore lasts (P+1)·(W+1) system cycles, where P is the prescale value. For a near 50% duty the caller programs H = floor((W+1)/2 − 1). The wrap point plays the role of the divider value N. Legal settings are W ≥ 1 and H < W.

Beside the clock line the block drives two single-cycle strobes. Both are registered in the same cycle as the line change they mark, so a shifter in the system clock domain knows when to sample and when to launch. A full-rate bypass sends the system clock itself to the line and raises both strobes on every cycle. The rest level of the line is selectable. A clock-off input holds the line at rest while the counters keep running.

The clock runs only while the run input is high. When the run input falls, the current period is played to its end before the line settles, so no shortened pulse appears. Configuration inputs must stay stable while the divider runs.

Top module: `sck_divider`

## Requirements
- R1: In divided mode, with the run input first sampled high at edge e0 and k counting cycles from the cycle after e0 (k=0), let T = floor(k/(P+1)) and c = (T−1) mod (W+1). The line is at the active level exactly when T ≥ 1 and H ≤ c < W, so the period is (P+1)·(W+1) cycles.
- R2: Within one period the line is active for (W−H)·(P+1) system cycles.
- R3: sample_o is high for one cycle in exactly the cycle the line enters the active level. launch_o is high for one cycle in exactly the cycle it returns to rest. In divided mode the two strobes are never high together.
- R4: While not running, the line sits at the rest level given by idle_high_i (1 = rests high). The active level is its inverse.
- R5: In cycle k=0 the line is at rest and no strobe is raised. Counting starts from zero in that cycle.
- R6: When the run input falls mid-period, the period completes, including its launch strobe. From then on the line stays at rest and both strobes stay low.
- R7: With bypass_i high and running, the line is active while the system clock is high and at rest while it is low. Both strobes are high every cycle, and the prescale, wrap and high-point values have no effect. One cycle after the run input falls, the line rests and the strobes clear.
- R8: With clk_off_i high, the line is held at the rest level while the strobes keep their normal timing.
- R9: During reset the line is at the rest level and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en_i | input | 1 | Run request; clock toggles while high |
| bypass_i | input | 1 | 1: line follows the system clock |
| clk_off_i | input | 1 | 1: line held at rest level |
| idle_high_i | input | 1 | Rest level of the line |
| pre_div_i | input | PRE_W | Prescale value P (ratio P+1) |
| wrap_pt_i | input | CNT_W | Wrap point W (divider N) |
| high_pt_i | input | CNT_W | High point H |
| sck_o | output | 1 | Serial clock line |
| launch_o | output | 1 | Strobe on the return-to-rest edge |
| sample_o | output | 1 | Strobe on the rest-to-active edge |

## Verification
The divided path is swept over every prescale value 0 to 3 and every wrap point 1 to 5, with the duty-centred high point and both rest levels. Each cycle is compared against the closed-form tick and count formula. This separates a wrong prescale ratio, an off-by-one wrap and a misplaced high point, and the duty count catches an asymmetric pulse. Every run ends with the run input dropped mid-period, which shows whether the last pulse is cut short or the line stays busy afterwards. Separate runs in bypass with deliberately odd divider values, and with the clock forced off, show that those controls override the line and not the strobe timing.

// File: rtl/sck_div_pkg.sv
package sck_div_pkg;

    typedef struct packed {
        logic run;     // divider active
        logic phase;   // 1: line at active level
        logic launch;  // return-to-rest strobe
        logic sample;  // rest-to-active strobe
    } edge_flags_t;

    localparam edge_flags_t FLAGS_RESET = '0;

endpackage

// File: rtl/sck_prescale.sv
module sck_prescale #(
    parameter int PRE_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [PRE_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = en_i && (st_q.cnt == div_i);
        if (!en_i) begin
            st_d.cnt = '0;
        end else if (tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sck_phase_ctr.sv
module sck_phase_ctr
    import sck_div_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en_i,
    input  logic             bypass_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] wrap_pt_i,
    input  logic [CNT_W-1:0] high_pt_i,
    output edge_flags_t      flags_o
);
    typedef struct packed {
        edge_flags_t      f;
        logic [CNT_W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.f.launch = 1'b0;
        st_d.f.sample = 1'b0;
        if (!st_q.f.run) begin
            st_d.cnt     = '0;
            st_d.f.phase = 1'b0;
            st_d.f.run   = run_en_i;
        end else if (bypass_i) begin
            // full-rate path: no counting, stop on the next edge
            st_d.cnt     = '0;
            st_d.f.phase = 1'b0;
            st_d.f.run   = run_en_i;
        end else if (tick_i) begin
            if (st_q.cnt == wrap_pt_i) begin
                // end of period: back to rest, stop here if asked
                st_d.cnt      = '0;
                st_d.f.phase  = 1'b0;
                st_d.f.launch = 1'b1;
                st_d.f.run    = run_en_i;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == high_pt_i) begin
                    st_d.f.phase  = 1'b1;
                    st_d.f.sample = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.f   <= FLAGS_RESET;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.f;
endmodule

// File: rtl/sck_out_stage.sv
module sck_out_stage
    import sck_div_pkg::*;
(
    input  logic        clk,
    input  edge_flags_t flags_i,
    input  logic        bypass_i,
    input  logic        clk_off_i,
    input  logic        idle_high_i,
    output logic        sck_o,
    output logic        launch_o,
    output logic        sample_o
);
    logic active;

    always_comb begin
        if (bypass_i) begin
            active   = flags_i.run & clk;
            launch_o = flags_i.run;
            sample_o = flags_i.run;
        end else begin
            active   = flags_i.phase;
            launch_o = flags_i.launch;
            sample_o = flags_i.sample;
        end
        sck_o = clk_off_i ? idle_high_i : (idle_high_i ^ active);
    end
endmodule

// File: rtl/sck_divider.sv
module sck_divider
    import sck_div_pkg::*;
#(
    parameter int PRE_W = 13,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en_i,
    input  logic             bypass_i,
    input  logic             clk_off_i,
    input  logic             idle_high_i,
    input  logic [PRE_W-1:0] pre_div_i,
    input  logic [CNT_W-1:0] wrap_pt_i,
    input  logic [CNT_W-1:0] high_pt_i,
    output logic             sck_o,
    output logic             launch_o,
    output logic             sample_o
);
    edge_flags_t flags;
    logic        pre_en;
    logic        tick;

    assign pre_en = flags.run & ~bypass_i;

    sck_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (pre_en),
        .div_i  (pre_div_i),
        .tick_o (tick)
    );

    sck_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en_i  (run_en_i),
        .bypass_i  (bypass_i),
        .tick_i    (tick),
        .wrap_pt_i (wrap_pt_i),
        .high_pt_i (high_pt_i),
        .flags_o   (flags)
    );

    sck_out_stage u_out (
        .clk         (clk),
        .flags_i     (flags),
        .bypass_i    (bypass_i),
        .clk_off_i   (clk_off_i),
        .idle_high_i (idle_high_i),
        .sck_o       (sck_o),
        .launch_o    (launch_o),
        .sample_o    (sample_o)
    );
endmodule

// File: rtl/sck_divider_chk.sv
module sck_divider_chk (
    input logic clk,
    input logic rst_n,
    input logic bypass_i,
    input logic clk_off_i,
    input logic idle_high_i,
    input logic sck_o,
    input logic launch_o,
    input logic sample_o
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass_i |-> !(launch_o && sample_o)); // R3

    AST_SAMPLE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_i && !clk_off_i && sample_o) |-> (sck_o != idle_high_i)); // R3

    AST_LAUNCH_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_i && !clk_off_i && launch_o) |-> (sck_o == idle_high_i)); // R3

    AST_OFF_REST: assert property (@(posedge clk) disable iff (!rst_n)
        clk_off_i |-> (sck_o == idle_high_i)); // R8

    AST_EDGE_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_i && !clk_off_i && !$past(bypass_i) && !$past(clk_off_i)
         && (idle_high_i == $past(idle_high_i)) && (sck_o != $past(sck_o)))
        |-> (launch_o || sample_o)); // R1

    AST_BYPASS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_i |-> (launch_o == sample_o)); // R7
endmodule

bind sck_divider sck_divider_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bypass_i    (bypass_i),
    .clk_off_i   (clk_off_i),
    .idle_high_i (idle_high_i),
    .sck_o       (sck_o),
    .launch_o    (launch_o),
    .sample_o    (sample_o)
);

// File: tb/sck_divider_tb_top.sv
module sck_divider_tb_top;
    localparam int PRE_W = 13;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_en = 1'b0;
    logic             bypass = 1'b0;
    logic             clk_off = 1'b0;
    logic             idle_high = 1'b1;
    logic [PRE_W-1:0] pre_div = '0;
    logic [CNT_W-1:0] wrap_pt = 6'd1;
    logic [CNT_W-1:0] high_pt = '0;
    logic             sck, launch, sample;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sck_divider #(.PRE_W(PRE_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en_i(run_en), .bypass_i(bypass),
        .clk_off_i(clk_off), .idle_high_i(idle_high), .pre_div_i(pre_div),
        .wrap_pt_i(wrap_pt), .high_pt_i(high_pt),
        .sck_o(sck), .launch_o(launch), .sample_o(sample)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // one divided run: start, two periods, drop run mid second period, quiet tail
    task automatic run_div(input int pre, input int n, input bit idl, input bit off);
        int h, per, act_cnt;
        h   = (n + 1) / 2 - 1;
        per = (n + 1) * (pre + 1);
        pre_div   = PRE_W'(pre);
        wrap_pt   = CNT_W'(n);
        high_pt   = CNT_W'(h);
        idle_high = idl;
        clk_off   = off;
        bypass    = 1'b0;
        run_en    = 1'b1;
        act_cnt   = 0;
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k <= 3 * per; k++) begin
            int t, c;
            bit act, smp, lau, first;
            t = k / (pre + 1);
            c = (t > 0) ? (t - 1) % (n + 1) : 0;
            first = (t > 0) && (k % (pre + 1) == 0);
            act = (t > 0) && (c >= h) && (c < n);
            smp = first && (c == h);
            lau = first && (c == n);
            if (k > 2 * per) begin
                act = 1'b0; smp = 1'b0; lau = 1'b0;
            end
            if (k >= 1 && k <= per && act) act_cnt++;
            if (off)
                chk("R8 line held at rest", int'(sck), int'(idl));
            else if (k == 0)
                chk("R5 first cycle at rest", int'(sck), int'(idl));
            else if (k > 2 * per)
                chk("R6 line at rest after stop", int'(sck), int'(idl));
            else
                chk("R1 line level", int'(sck), int'(idl ^ act));
            if (k > 2 * per) begin
                chk("R6 no sample after stop", int'(sample), 0);
                chk("R6 no launch after stop", int'(launch), 0);
            end else begin
                chk("R3 sample strobe", int'(sample), int'(smp));
                chk("R3 launch strobe", int'(launch), int'(lau));
            end
            if (k == per + 1) run_en = 1'b0;
            if (k == per && !off)
                chk("R2 active cycles per period", act_cnt, (n - h) * (pre + 1));
            @(negedge clk);
        end
        chk("R4 rest level between runs", int'(sck), int'(idl));
        clk_off = 1'b0;
    endtask

    initial begin
        // reset state
        #5;
        chk("R9 reset line at rest", int'(sck), 1);
        chk("R9 reset sample low", int'(sample), 0);
        chk("R9 reset launch low", int'(launch), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 idle before first run", int'(sck), 1);

        // divided sweep
        for (int idl = 0; idl < 2; idl++)
            for (int pre = 0; pre < 4; pre++)
                for (int n = 1; n <= 5; n++)
                    run_div(pre, n, idl[0], 1'b0);

        // clock forced off, strobes keep timing
        run_div(1, 3, 1'b0, 1'b1);
        run_div(2, 4, 1'b1, 1'b1);

        // bypass with odd divider values that must be ignored
        pre_div   = PRE_W'(7);
        wrap_pt   = CNT_W'(5);
        high_pt   = CNT_W'(2);
        idle_high = 1'b1;
        bypass    = 1'b1;
        run_en    = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 6; i++) begin
            #5;
            chk("R7 bypass active while clock high", int'(sck), 0);
            chk("R7 bypass sample every cycle", int'(sample), 1);
            chk("R7 bypass launch every cycle", int'(launch), 1);
            @(negedge clk);
            chk("R7 bypass rest while clock low", int'(sck), 1);
            @(posedge clk);
        end
        @(negedge clk);
        run_en = 1'b0;
        @(posedge clk);
        #5;
        chk("R7 bypass stopped line at rest", int'(sck), 1);
        chk("R7 bypass stopped sample low", int'(sample), 0);
        chk("R7 bypass stopped launch low", int'(launch), 0);
        @(negedge clk);
        bypass = 1'b0;
        @(negedge clk);
        chk("R4 rest after bypass", int'(sck), 1);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule